// File: doc/BRIEF.md
# Bus Power-Fail Detection Filter

This block cleans up the raw output of a supply-voltage comparator on a two-wire field bus and turns it into usable power-fail indications. The comparator bit is high while the bus voltage sits below its threshold. Data telegrams ride on the DC level of the bus, so the raw bit contains short dips.

The comparator bit first passes through a two-flop synchronizer. A symmetric deglitch stage then drops every level shorter than a set number of microseconds. After that, a second stage applies one delay before asserting the power-fail state and a different delay before releasing it. The result drives a dedicated active-high output whenever the block is in master or repeater mode.

In master mode the block can also force the receive-data line high. The line is forced once the deglitched condition has lasted a minimum activation time. If the condition ends before a further qualification period has passed, the line drops at once. If the condition outlasts that period, the indication is held for a fixed hold time and released a set time after the condition goes away. All timing is counted on a 1 µs enable tick derived from the system clock.

Top module: `pwr_fail_filter`

## Requirements
- R1: `mode_i` selects the operating mode: 2'b00 is slave, 2'b01 is master, 2'b10 is repeater, and 2'b11 behaves as slave. In slave mode `pf_o` stays low and `rx_data_o` equals `rx_data_i` for any comparator activity.
- R2: A comparator level that lasts fewer than `GLITCH_US` microseconds is discarded and affects neither output. A level that lasts W ≥ `GLITCH_US` microseconds reaches the later stages as a condition exactly W microseconds long.
- R3: In master or repeater mode, `pf_o` goes high only if the deglitched condition lasts at least `PF_ON_US` µs. A condition of W µs gives a `pf_o` pulse of exactly (W − `PF_ON_US` + `PF_OFF_US`) µs. `pf_o` changes only on a timebase tick.
- R4: A deglitched low gap in the condition that is shorter than `PF_OFF_US` µs does not release `pf_o`. A gap of at least `PF_OFF_US` µs does release it.
- R5: Whenever the power-fail override is not active (always in slave and repeater mode), `rx_data_o` equals `rx_data_i` in the same cycle.
- R6: In master mode, `rx_data_o` is forced high once the condition has lasted `RX_ON_US` µs. If the condition lasts W µs with `RX_ON_US` ≤ W < `RX_ON_US` + `RX_EXT_US`, the line is forced for exactly (W − `RX_ON_US`) µs and drops in the same cycle that the condition ends.
- R7: In master mode, a condition lasting W ≥ `RX_ON_US` + `RX_EXT_US` µs holds the override for at least `RX_HOLD_US` µs after qualification. The forced time is (max(W, `RX_ON_US` + `RX_EXT_US` + `RX_HOLD_US`) − `RX_ON_US` + `RX_REL_US`) µs.
- R8: After the hold, the override ends `RX_REL_US` µs after the condition ends. If the condition returns within that release time, the override continues without a break.
- R9: While `rst_ni` is low and right after it is released, `pf_o` is low and `rx_data_o` equals `rx_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode (00 slave, 01 master, 10 repeater) |
| cmp_i | input | 1 | Raw comparator bit, high when the bus voltage is below threshold |
| rx_data_i | input | 1 | Decoded receive data from the bus receiver |
| pf_o | output | 1 | Filtered power-fail indication, active high |
| rx_data_o | output | 1 | Receive data, forced high by power fail in master mode |

## Verification
The bench sweeps the comparator pulse width across every microsecond value from one to well past the hold threshold, in each mode. For every width it compares the exact number of cycles each output stays high with the arithmetic formula. A glitch filter that is off by one tick would pass pulses one microsecond too short. A design that swapped the assert and release delays, or dropped the hold, would produce forced durations that do not match the formula. A gap sweep inside a long power fail shows that the receive-data override and `pf_o` break at different gap lengths; a shared or misrouted release delay would break both at the same gap. Receive-data passthrough is checked in slave, repeater and idle master mode, so an override that leaks outside master mode is caught.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    MODE_SLAVE    = 2'd0,
    MODE_MASTER   = 2'd1,
    MODE_REPEATER = 2'd2,
    MODE_RSVD     = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_SIG, RX_HOLD, RX_STAY, RX_REL
  } rx_state_e;

  // counter width for a delay in ticks, never below 8 bits
  function automatic int unsigned cnt_width(int unsigned max_val);
    int unsigned w;
    w = $clog2(max_val + 1);
    return (w < 8) ? 8 : w;
  endfunction
endpackage

// File: rtl/us_tick.sv
module us_tick #(
  parameter int unsigned CLK_PER_US = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/level_filter.sv
// Output follows the input once it has differed for RISE_US (to 1) or FALL_US (to 0) ticks.
module level_filter #(
  parameter int unsigned RISE_US = 6,
  parameter int unsigned FALL_US = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic in_i,
  output logic out_o
);
  localparam int unsigned MAXD = (RISE_US > FALL_US) ? RISE_US : FALL_US;
  localparam int unsigned CW   = pf_pkg::cnt_width(MAXD);
  localparam logic [CW-1:0] RISE_LAST = CW'(RISE_US - 1);
  localparam logic [CW-1:0] FALL_LAST = CW'(FALL_US - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit = out_o ? FALL_LAST : RISE_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o <= 1'b0;
      cnt_q <= '0;
    end else if (clr_i) begin
      out_o <= 1'b0;
      cnt_q <= '0;
    end else if (in_i == out_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == limit) begin
        out_o <= in_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_override_fsm.sv
module rx_override_fsm #(
  parameter int unsigned ON_US   = 64,
  parameter int unsigned EXT_US  = 64,
  parameter int unsigned HOLD_US = 128,
  parameter int unsigned REL_US  = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic cond_i,
  output logic force_o
);
  import pf_pkg::*;

  localparam int unsigned M1   = (ON_US > EXT_US) ? ON_US : EXT_US;
  localparam int unsigned M2   = (HOLD_US > REL_US) ? HOLD_US : REL_US;
  localparam int unsigned MAXD = (M1 > M2) ? M1 : M2;
  localparam int unsigned CW   = cnt_width(MAXD);
  localparam logic [CW-1:0] ON_LAST   = CW'(ON_US - 1);
  localparam logic [CW-1:0] EXT_LAST  = CW'(EXT_US - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_US - 1);
  localparam logic [CW-1:0] REL_LAST  = CW'(REL_US - 1);

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
    end else if (!en_i) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        RX_IDLE: begin
          if (!cond_i) cnt_q <= '0;
          else if (tick_i) begin
            if (cnt_q == ON_LAST) begin
              state_q <= RX_SIG;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_SIG: begin
          // early end: drop straight back, no hold
          if (!cond_i) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
          end else if (tick_i) begin
            if (cnt_q == EXT_LAST) begin
              state_q <= RX_HOLD;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_HOLD: begin
          if (tick_i) begin
            if (cnt_q == HOLD_LAST) begin
              state_q <= RX_STAY;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STAY: begin
          if (!cond_i) begin
            state_q <= RX_REL;
            cnt_q   <= '0;
          end
        end
        RX_REL: begin
          if (cond_i) begin
            state_q <= RX_STAY;
            cnt_q   <= '0;
          end else if (tick_i) begin
            if (cnt_q == REL_LAST) begin
              state_q <= RX_IDLE;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= RX_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign force_o = ((state_q == RX_SIG) && cond_i) || (state_q == RX_HOLD) ||
                   (state_q == RX_STAY) || (state_q == RX_REL);
endmodule

// File: rtl/pwr_fail_filter.sv
module pwr_fail_filter #(
  parameter int unsigned CLK_PER_US  = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned GLITCH_US   = 6,
  parameter int unsigned PF_ON_US    = 64,
  parameter int unsigned PF_OFF_US   = 5,
  parameter int unsigned RX_ON_US    = 64,
  parameter int unsigned RX_EXT_US   = 64,
  parameter int unsigned RX_HOLD_US  = 128,
  parameter int unsigned RX_REL_US   = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       cmp_i,
  input  logic       rx_data_i,
  output logic       pf_o,
  output logic       rx_data_o
);
  import pf_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic tick;
  logic pf_en, master, clr;
  logic cond, pf_q, rx_force;

  assign pf_en  = (mode_e'(mode_i) == MODE_MASTER) || (mode_e'(mode_i) == MODE_REPEATER);
  assign master = (mode_e'(mode_i) == MODE_MASTER);
  assign clr    = !pf_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], cmp_i};
  end

  us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  level_filter #(.RISE_US(GLITCH_US), .FALL_US(GLITCH_US)) u_deglitch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .tick_i(tick),
    .in_i  (sync_q[SYNC_STAGES-1]),
    .out_o (cond)
  );

  level_filter #(.RISE_US(PF_ON_US), .FALL_US(PF_OFF_US)) u_asym (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .tick_i(tick),
    .in_i  (cond),
    .out_o (pf_q)
  );

  rx_override_fsm #(
    .ON_US  (RX_ON_US),
    .EXT_US (RX_EXT_US),
    .HOLD_US(RX_HOLD_US),
    .REL_US (RX_REL_US)
  ) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (master),
    .tick_i (tick),
    .cond_i (cond),
    .force_o(rx_force)
  );

  assign pf_o      = pf_q & pf_en;
  assign rx_data_o = (master & rx_force) | rx_data_i;

endmodule

// File: rtl/pwr_fail_filter_chk.sv
module pwr_fail_filter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       rx_data_i,
  input logic       pf_o,
  input logic       rx_data_o,
  input logic       tick_i,
  input logic       cond_i,
  input logic       force_i
);
  // R1
  slave_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(mode_i) && (mode_i == 2'd0 || mode_i == 2'd3)) |-> (!pf_o && !force_i));

  // R2
  tick_sparse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);

  // R3
  pf_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(pf_o) && $stable(mode_i)) |-> $past(tick_i));

  // R5
  rx_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !force_i |-> (rx_data_o == rx_data_i));

  // R6
  rx_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(force_i) && $stable(mode_i)) |-> (!cond_i || $past(!cond_i)));
endmodule

bind pwr_fail_filter pwr_fail_filter_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .rx_data_i(rx_data_i),
  .pf_o     (pf_o),
  .rx_data_o(rx_data_o),
  .tick_i   (tick),
  .cond_i   (cond),
  .force_i  (rx_force)
);

// File: tb/test_pwr_fail_filter.sv
module test_pwr_fail_filter;
  localparam int CLK_PERIOD = 10;
  localparam int P    = 2;
  localparam int G    = 3;
  localparam int ON   = 5;
  localparam int OFF  = 4;
  localparam int RON  = 4;
  localparam int REXT = 3;
  localparam int RHLD = 5;
  localparam int RREL = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic cmp_i = 1'b0;
  logic rx_data_i = 1'b0;
  logic pf_o, rx_data_o;

  int n_chk = 0;
  int n_bad = 0;

  pwr_fail_filter #(
    .CLK_PER_US(P), .SYNC_STAGES(2), .GLITCH_US(G), .PF_ON_US(ON), .PF_OFF_US(OFF),
    .RX_ON_US(RON), .RX_EXT_US(REXT), .RX_HOLD_US(RHLD), .RX_REL_US(RREL)
  ) i_pwr_fail_filter (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .cmp_i(cmp_i),
    .rx_data_i(rx_data_i), .pf_o(pf_o), .rx_data_o(rx_data_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic idle_us(input int us);
    for (int i = 0; i < us * P; i++) @(posedge clk);
    #1;
  endtask

  // single pulse of w us; returns high cycles and rising edges of both outputs
  task automatic pulse_trial(input int w, output int pf_hi, output int rx_hi,
                             output int pf_up, output int rx_up);
    logic pf_prev, rx_prev;
    pf_hi = 0; rx_hi = 0; pf_up = 0; rx_up = 0;
    pf_prev = pf_o; rx_prev = rx_data_o;
    for (int i = 0; i < (w + 40) * P; i++) begin
      @(posedge clk); #1;
      cmp_i = (i < w * P);
      @(negedge clk);
      if (pf_o) pf_hi++;
      if (rx_data_o) rx_hi++;
      if (pf_o && !pf_prev) pf_up++;
      if (rx_data_o && !rx_prev) rx_up++;
      pf_prev = pf_o; rx_prev = rx_data_o;
    end
  endtask

  // long fail, gap of l us, long fail again
  task automatic gap_trial(input int l, output int pf_up, output int rx_up);
    logic pf_prev, rx_prev;
    pf_up = 0; rx_up = 0;
    pf_prev = pf_o; rx_prev = rx_data_o;
    for (int i = 0; i < (100 + l) * P; i++) begin
      @(posedge clk); #1;
      cmp_i = (i < 30 * P) || (i >= (30 + l) * P && i < (60 + l) * P);
      @(negedge clk);
      if (pf_o && !pf_prev) pf_up++;
      if (rx_data_o && !rx_prev) rx_up++;
      pf_prev = pf_o; rx_prev = rx_data_o;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int pf_hi, rx_hi, pf_up, rx_up, exp_pf, exp_rx;
    // R9 reset state
    rx_data_i = 1'b1; cmp_i = 1'b1; mode_i = 2'd1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R9 pf_o in reset", pf_o, 0);
    check("R9 rx_data_o in reset", rx_data_o, 1);
    cmp_i = 1'b0;
    @(posedge clk); #1; rst_ni = 1'b1;
    @(negedge clk);
    check("R9 pf_o after reset", pf_o, 0);
    check("R9 rx_data_o after reset", rx_data_o, 1);

    // R5 passthrough in idle master mode
    for (int v = 0; v < 2; v++) begin
      rx_data_i = v[0];
      @(negedge clk);
      check("R5 idle master passthrough", rx_data_o, v);
    end
    rx_data_i = 1'b0;

    // R1..R3, R6, R7 width sweep per mode
    for (int m = 0; m < 4; m++) begin
      mode_i = m[1:0];
      idle_us(40);
      for (int w = 1; w <= 16; w++) begin
        pulse_trial(w, pf_hi, rx_hi, pf_up, rx_up);
        exp_pf = 0; exp_rx = 0;
        if ((m == 1 || m == 2) && w >= imax(G, ON)) exp_pf = (w - ON + OFF) * P;
        if (m == 1 && w >= imax(G, RON)) begin
          if (w < RON + REXT) exp_rx = (w - RON) * P;                         // R6
          else exp_rx = (imax(w, RON + REXT + RHLD) - RON + RREL) * P;        // R7
        end
        if (m == 0 || m == 3) begin
          check("R1 slave pf_o cycles", pf_hi, 0);
          check("R1 slave rx_data_o cycles", rx_hi, 0);
        end else if (w < G) begin
          check("R2 glitch pf_o cycles", pf_hi, 0);
          check("R2 glitch rx_data_o cycles", rx_hi, 0);
        end else begin
          check("R3 pf_o high cycles", pf_hi, exp_pf);
          if (m == 2) check("R5 repeater rx_data_o cycles", rx_hi, 0);
          else if (w < RON + REXT) check("R6 short override cycles", rx_hi, exp_rx);
          else check("R7 held override cycles", rx_hi, exp_rx);
        end
        check("R3 pf_o single pulse", pf_up, (exp_pf > 0) ? 1 : 0);
      end
    end

    // R4, R8 gap sweep in master mode
    mode_i = 2'd1;
    idle_us(40);
    for (int l = 1; l <= 6; l++) begin
      gap_trial(l, pf_up, rx_up);
      check("R4 pf_o pulses across gap", pf_up, (l >= imax(G, OFF)) ? 2 : 1);
      check("R8 rx_data_o pulses across gap", rx_up, (l >= imax(G, RREL)) ? 2 : 1);
    end

    // R5 passthrough while power fail is active in repeater mode
    mode_i = 2'd2;
    idle_us(40);
    cmp_i = 1'b1;
    idle_us(20);
    for (int v = 0; v < 2; v++) begin
      rx_data_i = v[0];
      @(negedge clk);
      check("R3 pf_o active in repeater", pf_o, 1);
      check("R5 repeater passthrough during fail", rx_data_o, v);
    end
    // R1 same stimulus in slave mode
    mode_i = 2'd0;
    idle_us(20);
    for (int v = 0; v < 2; v++) begin
      rx_data_i = v[0];
      @(negedge clk);
      check("R1 slave pf_o during fail", pf_o, 0);
      check("R1 slave passthrough during fail", rx_data_o, v);
    end
    cmp_i = 1'b0;
    idle_us(10);

    summary();
    $finish;
  end
endmodule